// File: doc/BRIEF.md
# Dual-Width Code Prefetch Queue

This block keeps a sixteen-byte buffer of raw instruction bytes between a 32-bit memory read port and an instruction decoder. On the memory side it sends doubleword-aligned read requests whenever enough room is left. Each request carries an epoch tag, and the block appends every returned doubleword to the buffer in address order. On the decoder side it shows the oldest byte for ordinary byte-by-byte decoding. When the decoder knows that a displacement or immediate follows, it can instead take a little-endian literal of one, two or four bytes in a single cycle.

A flush input empties the buffer at once and restarts fetching from a new linear address. Responses to requests made before the flush come back with an old epoch tag and are dropped. When the new address is not doubleword aligned, the block trims the leading bytes of the first returned doubleword. Occupancy and the two valid outputs let the decoder stall without reading internal state.

Top module: `code_prefetch_queue`

## Requirements
- R1: After reset the buffer is empty: `count_o` is 0 and `byte_valid_o` and `win_valid_o` are low. The first request goes to the aligned `RESET_ADDR` (default 0x0000FFF0) with tag 0.
- R2: `req_addr_o` is always doubleword aligned. A request that is not acknowledged holds its address until `req_ack_i` is high or a flush arrives. Each acknowledged request advances the next address by 4.
- R3: `req_o` is high only when the occupancy plus 4 bytes for each outstanding request plus 4 bytes for the new one fits in 16 bytes, and fewer than `MAX_OUT` (2) requests are outstanding. Occupancy never exceeds 16.
- R4: After an acknowledged request, `req_o` stays low for the next `FETCH_GAP`-1 cycles (default: one cycle), which models four bytes every two clocks.
- R5: An accepted response appends its four bytes in order: `rsp_data_i[7:0]` is the lowest address and enters first.
- R6: `byte_o` is the oldest byte while `byte_valid_o` (occupancy not zero) is high. `pop_byte_i` removes one byte and has no effect on an empty buffer.
- R7: `win_sel_i` codes 0, 1 and 2 select a window of 1, 2 or 4 bytes. `win_data_o` holds those oldest bytes little-endian with the unused upper bytes zero. `win_valid_o` is high only when at least that many bytes are present, and then `win_take_i` removes them. Code 3 is never valid and its take does nothing.
- R8: When both `win_take_i` (with a valid window) and `pop_byte_i` are high, only the window is consumed.
- R9: During a flush cycle `req_o` is low and nothing is consumed. The next cycle the buffer is empty, and fetching resumes at `flush_addr_i` with its low two bits cleared.
- R10: The first accepted response after a flush discards its lowest `flush_addr_i[1:0]` bytes, so the first byte presented is the one at the flush address.
- R11: Each flush advances the epoch, which is presented on `req_tag_o`. A response whose `rsp_tag_i` differs from the current epoch, or that arrives in a flush cycle, is ignored.
- R12: A push and a pop in the same cycle both take effect: the occupancy changes by pushed bytes minus consumed bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Empty the buffer and redirect fetching |
| flush_addr_i | input | ADDR_W | New fetch target (may be unaligned) |
| req_o | output | 1 | Fetch request valid |
| req_addr_o | output | ADDR_W | Aligned fetch address |
| req_tag_o | output | TAG_W | Epoch tag of the request |
| req_ack_i | input | 1 | Memory accepts the request this cycle |
| rsp_valid_i | input | 1 | Returned doubleword valid |
| rsp_data_i | input | 32 | Returned doubleword, lowest address in bits 7:0 |
| rsp_tag_i | input | TAG_W | Epoch tag echoed with the response |
| byte_o | output | 8 | Oldest byte in the buffer |
| byte_valid_o | output | 1 | At least one byte present |
| pop_byte_i | input | 1 | Consume one byte |
| win_sel_i | input | 2 | Window length code: 0=1, 1=2, 2=4 bytes, 3 reserved |
| win_data_o | output | 32 | Little-endian window, zero-extended |
| win_valid_o | output | 1 | Selected window fully present |
| win_take_i | input | 1 | Consume the selected window |
| count_o | output | CNT_W | Occupancy in bytes |

## Verification
The assertions check the cycle-local rules on every cycle: aligned request addresses, a request held stable until it is acknowledged, the quiet cycle after an issue, no request during a flush, an empty buffer after a flush, the bound on occupancy and on growth per cycle, and a four-byte window being valid only when four bytes are present. Byte order, the trimming of an unaligned first doubleword, the dropping of stale-epoch responses and the priority of the window over the byte pop all depend on the data history. Only the bench's behavioural model can show these, by following the byte stream through fills, random consumption, back-to-back flushes and withheld acknowledges.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  typedef enum logic [1:0] {
    WIN_B1   = 2'd0,
    WIN_B2   = 2'd1,
    WIN_B4   = 2'd2,
    WIN_RSVD = 2'd3
  } win_len_e;

  function automatic logic [2:0] win_bytes(input logic [1:0] sel);
    case (win_len_e'(sel))
      WIN_B1:  return 3'd1;
      WIN_B2:  return 3'd2;
      WIN_B4:  return 3'd4;
      default: return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/pfq_store.sv
// Byte ring: four write lanes, four read lanes. DEPTH must be a power of two, >= 4.
module pfq_store #(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic [2:0]       push_n_i,
  input  logic [31:0]      push_data_i,
  input  logic [2:0]       pop_n_i,
  output logic [31:0]      peek_o,
  output logic [CNT_W-1:0] count_o
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [7:0]       mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk_i) begin
    for (int l = 0; l < 4; l++) begin
      if (3'(l) < push_n_i) mem_q[wr_ptr_q + PTR_W'(l)] <= push_data_i[8*l +: 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (clear_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_q + PTR_W'(push_n_i);
      rd_ptr_q <= rd_ptr_q + PTR_W'(pop_n_i);
      count_q  <= count_q + CNT_W'(push_n_i) - CNT_W'(pop_n_i);
    end
  end

  for (genvar g = 0; g < 4; g++) begin : g_peek
    assign peek_o[8*g +: 8] = mem_q[rd_ptr_q + PTR_W'(g)];
  end

  assign count_o = count_q;
endmodule

// File: rtl/pfq_fetch.sv
module pfq_fetch #(
  parameter int              ADDR_W     = 32,
  parameter int              DEPTH      = 16,
  parameter int              CNT_W      = $clog2(DEPTH + 1),
  parameter int              MAX_OUT    = 2,
  parameter int              FETCH_GAP  = 2,
  parameter int              TAG_W      = 2,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic [ADDR_W-1:0] flush_addr_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [TAG_W-1:0]  req_tag_o,
  input  logic              req_ack_i,
  input  logic              rsp_valid_i,
  input  logic [31:0]       rsp_data_i,
  input  logic [TAG_W-1:0]  rsp_tag_i,
  output logic [2:0]        push_n_o,
  output logic [31:0]       push_data_o
);
  localparam int OUT_W = $clog2(MAX_OUT + 1);
  localparam int GAP_W = (FETCH_GAP > 1) ? $clog2(FETCH_GAP) : 1;
  localparam int SUM_W = CNT_W + OUT_W + 3;

  logic [ADDR_W-3:0] word_q;
  logic [OUT_W-1:0]  out_q;
  logic [GAP_W-1:0]  gap_q;
  logic [TAG_W-1:0]  epoch_q;
  logic [1:0]        skip_q;
  logic [SUM_W-1:0]  reserve;
  logic              issue, rsp_hit;

  // every outstanding request reserves a full doubleword
  assign reserve = SUM_W'(count_i) + ((SUM_W'(out_q) + SUM_W'(1)) << 2);
  assign req_o   = !flush_i && (gap_q == '0) && (out_q < OUT_W'(MAX_OUT))
                   && (reserve <= SUM_W'(DEPTH));
  assign req_addr_o = {word_q, 2'b00};
  assign req_tag_o  = epoch_q;
  assign issue      = req_o && req_ack_i;
  assign rsp_hit    = rsp_valid_i && (rsp_tag_i == epoch_q) && !flush_i;

  assign push_n_o    = rsp_hit ? (3'd4 - {1'b0, skip_q}) : 3'd0;
  assign push_data_o = rsp_data_i >> {skip_q, 3'b000};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q  <= RESET_ADDR[ADDR_W-1:2];
      skip_q  <= RESET_ADDR[1:0];
      out_q   <= '0;
      gap_q   <= '0;
      epoch_q <= '0;
    end else if (flush_i) begin
      word_q  <= flush_addr_i[ADDR_W-1:2];
      skip_q  <= flush_addr_i[1:0];
      out_q   <= '0;
      gap_q   <= '0;
      epoch_q <= epoch_q + TAG_W'(1);
    end else begin
      if (issue) word_q <= word_q + (ADDR_W-2)'(1);
      if (rsp_hit) skip_q <= 2'd0;
      case ({issue, rsp_hit})
        2'b10:   out_q <= out_q + OUT_W'(1);
        2'b01:   out_q <= out_q - OUT_W'(1);
        default: out_q <= out_q;
      endcase
      if (issue)             gap_q <= GAP_W'(FETCH_GAP - 1);
      else if (gap_q != '0)  gap_q <= gap_q - GAP_W'(1);
    end
  end
endmodule

// File: rtl/pfq_window.sv
module pfq_window #(
  parameter int CNT_W = 5
) (
  input  logic [31:0]      peek_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [1:0]       sel_i,
  output logic [31:0]      data_o,
  output logic             valid_o,
  output logic [2:0]       len_o
);
  import pfq_pkg::*;

  assign len_o   = win_bytes(sel_i);
  assign valid_o = (len_o != 3'd0) && (count_i >= CNT_W'(len_o));

  for (genvar g = 0; g < 4; g++) begin : g_lane
    assign data_o[8*g +: 8] = (3'(g) < len_o) ? peek_i[8*g +: 8] : 8'h00;
  end
endmodule

// File: rtl/code_prefetch_queue.sv
module code_prefetch_queue #(
  parameter int                ADDR_W     = 32,
  parameter int                DEPTH      = 16,
  parameter int                MAX_OUT    = 2,
  parameter int                FETCH_GAP  = 2,
  parameter int                TAG_W      = 2,
  parameter logic [ADDR_W-1:0] RESET_ADDR = 32'h0000_FFF0,
  localparam int               CNT_W      = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic [ADDR_W-1:0] flush_addr_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [TAG_W-1:0]  req_tag_o,
  input  logic              req_ack_i,
  input  logic              rsp_valid_i,
  input  logic [31:0]       rsp_data_i,
  input  logic [TAG_W-1:0]  rsp_tag_i,
  output logic [7:0]        byte_o,
  output logic              byte_valid_o,
  input  logic              pop_byte_i,
  input  logic [1:0]        win_sel_i,
  output logic [31:0]       win_data_o,
  output logic              win_valid_o,
  input  logic              win_take_i,
  output logic [CNT_W-1:0]  count_o
);
  logic [2:0]  push_n, pop_n, win_len;
  logic [31:0] push_data, peek;

  pfq_fetch #(
    .ADDR_W(ADDR_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .MAX_OUT(MAX_OUT),
    .FETCH_GAP(FETCH_GAP), .TAG_W(TAG_W), .RESET_ADDR(RESET_ADDR)
  ) u_fetch (
    .clk_i, .rst_ni, .flush_i, .flush_addr_i,
    .count_i     (count_o),
    .req_o, .req_addr_o, .req_tag_o, .req_ack_i,
    .rsp_valid_i, .rsp_data_i, .rsp_tag_i,
    .push_n_o    (push_n),
    .push_data_o (push_data)
  );

  pfq_store #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
    .clk_i, .rst_ni,
    .clear_i     (flush_i),
    .push_n_i    (push_n),
    .push_data_i (push_data),
    .pop_n_i     (pop_n),
    .peek_o      (peek),
    .count_o     (count_o)
  );

  pfq_window #(.CNT_W(CNT_W)) u_window (
    .peek_i  (peek),
    .count_i (count_o),
    .sel_i   (win_sel_i),
    .data_o  (win_data_o),
    .valid_o (win_valid_o),
    .len_o   (win_len)
  );

  assign byte_o       = peek[7:0];
  assign byte_valid_o = (count_o != '0);

  // window consume outranks the single-byte pop (R8)
  always_comb begin
    if (flush_i)                         pop_n = 3'd0;
    else if (win_take_i && win_valid_o)  pop_n = win_len;
    else if (pop_byte_i && byte_valid_o) pop_n = 3'd1;
    else                                 pop_n = 3'd0;
  end
endmodule

// File: rtl/pfq_checker.sv
module pfq_checker #(
  parameter int ADDR_W    = 32,
  parameter int DEPTH     = 16,
  parameter int FETCH_GAP = 2,
  parameter int CNT_W     = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              flush_i,
  input logic              req_o,
  input logic              req_ack_i,
  input logic [ADDR_W-1:0] req_addr_o,
  input logic [CNT_W-1:0]  count_o,
  input logic [1:0]        win_sel_i,
  input logic              win_valid_o
);
  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CNT_W'(DEPTH));

  p_aligned_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (req_addr_o[1:0] == 2'b00));

  p_req_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !req_ack_i && !flush_i) |=> (flush_i || (req_o && $stable(req_addr_o))));

  p_flush_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> !req_o);

  p_flush_empty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (count_o == '0));

  p_growth_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_i |=> (count_o <= $past(count_o) + CNT_W'(4)));

  p_win4_present_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_valid_o && win_sel_i == 2'd2) |-> (count_o >= CNT_W'(4)));

  if (FETCH_GAP >= 2) begin : g_gap
    p_cadence_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_o && req_ack_i) |=> !req_o);
  end
endmodule

bind code_prefetch_queue pfq_checker #(
  .ADDR_W(ADDR_W), .DEPTH(DEPTH), .FETCH_GAP(FETCH_GAP), .CNT_W(CNT_W)
) u_pfq_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i), .req_o(req_o),
  .req_ack_i(req_ack_i), .req_addr_o(req_addr_o), .count_o(count_o),
  .win_sel_i(win_sel_i), .win_valid_o(win_valid_o)
);

// File: tb/code_prefetch_queue_bench.sv
module code_prefetch_queue_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 3;
  localparam int TAG_W      = 2;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        flush_i = 1'b0;
  logic [31:0] flush_addr_i = '0;
  logic        req_o;
  logic [31:0] req_addr_o;
  logic [1:0]  req_tag_o;
  logic        req_ack_i = 1'b0;
  logic        rsp_valid_i = 1'b0;
  logic [31:0] rsp_data_i = '0;
  logic [1:0]  rsp_tag_i = '0;
  logic [7:0]  byte_o;
  logic        byte_valid_o;
  logic        pop_byte_i = 1'b0;
  logic [1:0]  win_sel_i = '0;
  logic [31:0] win_data_o;
  logic        win_valid_o;
  logic        win_take_i = 1'b0;
  logic [4:0]  count_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  code_prefetch_queue u_code_prefetch_queue (.*);

  int compared = 0, mismatched = 0, cyc = 0;
  bit done = 1'b0;

  logic [7:0]  mq[$];
  int          m_out, m_epoch, m_gap, m_skip;
  logic [31:0] m_faddr;
  logic [31:0] pa[$];
  int          pt[$], pr[$];

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {mem_byte(a + 3), mem_byte(a + 2), mem_byte(a + 1), mem_byte(a)};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic step(input bit fl, input logic [31:0] fa, input bit pb,
                      input bit wt, input logic [1:0] ws, input bit ack);
    bit          rv, hit, req_pred;
    int          n, wn;
    logic [31:0] rd, wexp;
    int          rt;
    @(negedge clk_i);
    rv = (pa.size() > 0) && (pr[0] <= cyc);
    rd = rv ? mem_word(pa[0]) : 32'h0;
    rt = rv ? pt[0] : 0;
    flush_i = fl; flush_addr_i = fa; pop_byte_i = pb; win_take_i = wt;
    win_sel_i = ws; req_ack_i = ack;
    rsp_valid_i = rv; rsp_data_i = rd; rsp_tag_i = rt[1:0];
    #1;
    n = mq.size();
    chk(count_o == 5'(n), "R3/R12", "count_o", 32'(count_o), 32'(n));
    chk(byte_valid_o == (n > 0), "R6", "byte_valid_o", 32'(byte_valid_o), 32'(n > 0));
    if (n > 0) chk(byte_o == mq[0], "R5/R6", "byte_o", 32'(byte_o), 32'(mq[0]));
    wn = (ws == 2'd0) ? 1 : (ws == 2'd1) ? 2 : (ws == 2'd2) ? 4 : 0;
    chk(win_valid_o == (wn != 0 && n >= wn), "R7", "win_valid_o",
        32'(win_valid_o), 32'(wn != 0 && n >= wn));
    if (wn != 0 && n >= wn) begin
      wexp = '0;
      for (int i = 0; i < wn; i++) wexp[8*i +: 8] = mq[i];
      chk(win_data_o == wexp, "R7", "win_data_o", win_data_o, wexp);
    end
    req_pred = !fl && (m_gap == 0) && (m_out < 2) && (n + 4*(m_out + 1) <= 16);
    chk(req_o == req_pred, "R3/R4/R9", "req_o", 32'(req_o), 32'(req_pred));
    if (req_pred) begin
      chk(req_addr_o == m_faddr, "R2/R9", "req_addr_o", req_addr_o, m_faddr);
      chk(req_tag_o == 2'(m_epoch), "R11", "req_tag_o", 32'(req_tag_o), 32'(m_epoch));
    end
    hit = 1'b0;
    if (rv) begin
      hit = (rt == m_epoch) && !fl;
      void'(pa.pop_front()); void'(pt.pop_front()); void'(pr.pop_front());
    end
    if (fl) begin
      mq.delete();
      m_out = 0; m_gap = 0;
      m_epoch = (m_epoch + 1) % 4;
      m_faddr = {fa[31:2], 2'b00};
      m_skip = int'(fa[1:0]);
    end else begin
      // R8: a valid window take wins over the byte pop
      if (wt && wn != 0 && n >= wn) begin
        for (int i = 0; i < wn; i++) void'(mq.pop_front());
      end else if (pb && n > 0) begin
        void'(mq.pop_front());
      end
      if (hit) begin
        for (int i = m_skip; i < 4; i++) mq.push_back(rd[8*i +: 8]);
        m_skip = 0;
        m_out--;
      end
      if (req_pred && ack) begin
        pa.push_back(m_faddr); pt.push_back(m_epoch); pr.push_back(cyc + LAT);
        m_faddr += 4; m_out++; m_gap = 1;
      end else if (m_gap > 0) begin
        m_gap--;
      end
    end
    cyc++;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    m_out = 0; m_epoch = 0; m_gap = 0; m_skip = 0; m_faddr = 32'h0000_FFF0;
    repeat (3) @(posedge clk_i);
    #2;
    chk(count_o == 5'd0, "R1", "count_o in reset", 32'(count_o), 0);
    chk(!byte_valid_o, "R1", "byte_valid_o in reset", 32'(byte_valid_o), 0);
    chk(!win_valid_o, "R1", "win_valid_o in reset", 32'(win_valid_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    chk(req_o && req_addr_o == 32'h0000_FFF0, "R1", "first request", req_addr_o, 32'h0000_FFF0);

    // fill without consuming: occupancy must settle at 16 (R3)
    for (int i = 0; i < 40; i++) step(0, 0, 0, 0, 2'd0, 1);
    chk(count_o == 5'd16, "R3", "full occupancy", 32'(count_o), 16);

    // byte pops with irregular acknowledges (R6, R12)
    for (int i = 0; i < 300; i++)
      step(0, 0, $urandom_range(0, 1) == 1, 0, 2'd0, $urandom_range(0, 3) != 0);

    // window takes mixed with byte pops, including reserved code (R7, R8)
    for (int i = 0; i < 300; i++)
      step(0, 0, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
           2'($urandom_range(0, 3)), $urandom_range(0, 4) != 0);

    // unaligned redirect (R10)
    step(1, 32'h0000_0203, 0, 0, 2'd0, 1);
    for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 2'd0, 1);
    @(posedge clk_i); #2;
    chk(byte_o == mem_byte(32'h203), "R10", "first byte after unaligned flush",
        32'(byte_o), 32'(mem_byte(32'h203)));

    // stale response after a second flush must be ignored (R11)
    step(1, 32'h0000_0300, 0, 0, 2'd0, 0);
    step(0, 0, 0, 0, 2'd0, 1);
    step(1, 32'h0000_0401, 0, 0, 2'd0, 0);
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 2'd0, 0);
    @(posedge clk_i); #2;
    chk(count_o == 5'd0, "R11", "count after stale response", 32'(count_o), 0);

    // everything at once, with random redirects
    for (int i = 0; i < 1500; i++)
      step($urandom_range(0, 29) == 0, $urandom, $urandom_range(0, 1) == 1,
           $urandom_range(0, 1) == 1, 2'($urandom_range(0, 3)),
           $urandom_range(0, 3) != 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule